// File: doc/BRIEF.md
# Serial Flash Sector Lock Register Controller

This block is the slave-side command logic of a serial flash that owns the volatile per-sector protection bits. It oversamples the serial bus (active-low select, serial clock, serial data in) with the system clock and assembles bytes from the data line on rising serial-clock edges, most significant bit first. A small command state machine recognises two commands. The first sets the write-enable latch. The second writes one sector's lock register. That write takes a three-byte address and a one-byte data value. It takes effect only when select is released exactly after the last data bit, the latch is set, and no program or erase cycle is running.

Each sector holds two bits. One is a write-lock bit that drives the sector's write-protect output. The other is a lock-down bit. Once it is set, the sector's register is frozen until reset. A combinational read port returns any sector's register. Program and erase engines sit outside the block and show up here only as a busy input.

States: `ST_IDLE` (select high), `ST_OPCODE` (first byte), `ST_ADDR` (three address bytes), `ST_DATA` (data byte), `ST_LOCK_END` (lock frame complete, waiting for select to rise), `ST_WREN_END` (enable frame complete, waiting for select to rise), `ST_IGNORE` (frame discarded). The transitions are:

- `ST_IDLE`→`ST_OPCODE` on a select fall.
- `ST_OPCODE`→`ST_ADDR` on byte 0xE5, →`ST_WREN_END` on byte 0x06, and →`ST_IGNORE` on any other byte.
- `ST_ADDR`→`ST_DATA` after the third address byte.
- `ST_DATA`→`ST_LOCK_END` on the data byte.
- `ST_LOCK_END` and `ST_WREN_END` go →`ST_IGNORE` on any further serial-clock rise.
- Every state except `ST_IDLE` goes →`ST_IDLE` on a select rise.

Top module: `sector_lock_ctrl`

## Requirements
- R1: After reset every sector register is 00, `wp_vec` is 0 and `wel` is 0.
- R2: A frame of exactly 8 bits carrying 0x06, ended by select rising, sets `wel`.
- R3: A frame of opcode 0xE5, a 24-bit address and a data byte (40 bits, all MSB first), ended by select rising after bit 40 with `wel`=1 and `busy`=0, loads the addressed sector's register from data bit 0 (write-lock) and data bit 1 (lock-down). `wp_vec[s]` equals sector s's write-lock bit, and other sectors are unchanged.
- R4: Only address bits 18..16 pick the sector (8 sectors of 64 KiB). The other address bits and data bits 7..2 have no effect.
- R5: A lock frame whose select rises after any bit count other than 40 changes no register and leaves `wel` unchanged.
- R6: A lock frame arriving with `wel`=0 changes nothing.
- R7: A lock frame whose closing select rise sees `busy`=1 is rejected, leaves the registers unchanged and leaves `wel` set.
- R8: An accepted lock frame clears `wel`.
- R9: When a sector's lock-down bit is 1, later accepted frames leave that sector's register unchanged but still clear `wel`.
- R10: A frame with any other opcode changes neither the registers nor `wel`.
- R11: `rd_lock` returns {lock-down, write-lock} of the sector selected by `rd_sector`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in |
| busy | input | 1 | Program/erase/write cycle running |
| rd_sector | input | 3 | Sector index for the read port |
| rd_lock | output | 2 | {lock-down, write-lock} of the selected sector |
| wp_vec | output | 8 | Per-sector write-protect (write-lock bits) |
| wel | output | 1 | Write-enable latch |

## Verification
The assertions assume that the serial clock is slow compared with the system clock. They also assume that data is stable around each serial-clock rise, and that select never changes in the same system cycle as a serial-clock rise. The bench drives every serial bit as four system cycles low and four high, with data set while the clock is low. It moves select only while the serial clock is low, with idle cycles on both sides. It holds `busy` steady across each whole frame, so the checks on `busy` and `wel` at the commit edge see settled values.

// File: rtl/slk_pkg.sv
package slk_pkg;

    localparam logic [7:0] OPC_LOCK_WR = 8'hE5;
    localparam logic [7:0] OPC_WR_EN   = 8'h06;
    localparam int         ADDR_BYTES  = 3;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_LOCK_END,
        ST_WREN_END,
        ST_IGNORE
    } cmd_state_t;

    typedef struct packed {
        logic down;
        logic wlock;
    } lock_t;

endpackage

// File: rtl/slk_spi_sampler.sv
module slk_spi_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n_in,
    input  logic       sclk_in,
    input  logic       mosi_in,
    output logic       cs_fall,
    output logic       cs_rise,
    output logic       bit_stb,
    output logic       byte_stb,
    output logic [7:0] byte_val
);

    // one synchroniser chain per bus line: {cs_n, sclk, mosi}
    logic [2:0] sync_r [SYNC_STAGES];
    logic       cs_s, sclk_s, mosi_s;
    logic       cs_prev, sclk_prev;
    logic [6:0] shreg;
    logic [2:0] bit_cnt;

    generate
        for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_r[g] <= 3'b100;
                end else if (g == 0) begin
                    sync_r[g] <= {cs_n_in, sclk_in, mosi_in};
                end else begin
                    sync_r[g] <= sync_r[(g == 0) ? 0 : g - 1];
                end
            end
        end
    endgenerate

    assign cs_s   = sync_r[SYNC_STAGES-1][2];
    assign sclk_s = sync_r[SYNC_STAGES-1][1];
    assign mosi_s = sync_r[SYNC_STAGES-1][0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_prev   <= cs_s;
            sclk_prev <= sclk_s;
        end
    end

    assign cs_fall  = !cs_s && cs_prev;
    assign cs_rise  = cs_s && !cs_prev;
    assign bit_stb  = !cs_s && sclk_s && !sclk_prev;
    assign byte_stb = bit_stb && (bit_cnt == 3'd7);
    assign byte_val = {shreg, mosi_s};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (cs_s) begin
            bit_cnt <= '0;
        end else if (bit_stb) begin
            shreg   <= {shreg[5:0], mosi_s};
            bit_cnt <= bit_cnt + 3'd1;
        end
    end

endmodule

// File: rtl/slk_cmd_fsm.sv
module slk_cmd_fsm
    import slk_pkg::*;
#(
    parameter int SECT_W   = 3,
    parameter int SECT_LSB = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall,
    input  logic              cs_rise,
    input  logic              bit_stb,
    input  logic              byte_stb,
    input  logic [7:0]        byte_val,
    input  logic              busy,
    output logic              wel,
    output logic              commit,
    output logic [SECT_W-1:0] commit_sector,
    output lock_t             commit_data
);

    localparam int IDX_W     = $clog2(ADDR_BYTES);
    // address byte (in arrival order) and bit that hold the sector field
    localparam int SECT_BYTE = ADDR_BYTES - 1 - SECT_LSB / 8;
    localparam int SECT_BIT  = SECT_LSB % 8;

    cmd_state_t        state, state_nx;
    logic [IDX_W-1:0]  addr_idx;
    logic [SECT_W-1:0] sect_r;
    lock_t             data_r;
    logic              wel_set, wel_clr;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (cs_fall) state_nx = ST_OPCODE;
            ST_OPCODE: begin
                if (cs_rise) state_nx = ST_IDLE;
                else if (byte_stb) begin
                    if (byte_val == OPC_LOCK_WR)    state_nx = ST_ADDR;
                    else if (byte_val == OPC_WR_EN) state_nx = ST_WREN_END;
                    else                            state_nx = ST_IGNORE;
                end
            end
            ST_ADDR: begin
                if (cs_rise) state_nx = ST_IDLE;
                else if (byte_stb && addr_idx == IDX_W'(ADDR_BYTES - 1)) state_nx = ST_DATA;
            end
            ST_DATA: begin
                if (cs_rise)       state_nx = ST_IDLE;
                else if (byte_stb) state_nx = ST_LOCK_END;
            end
            ST_LOCK_END, ST_WREN_END: begin
                if (cs_rise)      state_nx = ST_IDLE;
                else if (bit_stb) state_nx = ST_IGNORE;
            end
            ST_IGNORE:   if (cs_rise) state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        commit  = 1'b0;
        wel_set = 1'b0;
        unique case (state)
            ST_LOCK_END: commit  = cs_rise && wel && !busy;
            ST_WREN_END: wel_set = cs_rise;
            default: ;
        endcase
        wel_clr = commit;
    end

    assign commit_sector = sect_r;
    assign commit_data   = data_r;

    // frame datapath and enable latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_idx <= '0;
            sect_r   <= '0;
            data_r   <= '0;
            wel      <= 1'b0;
        end else begin
            if (state == ST_OPCODE) addr_idx <= '0;
            if (state == ST_ADDR && byte_stb) begin
                addr_idx <= addr_idx + 1'b1;
                if (addr_idx == IDX_W'(SECT_BYTE))
                    sect_r <= byte_val[SECT_BIT +: SECT_W];
            end
            if (state == ST_DATA && byte_stb)
                data_r <= lock_t'(byte_val[1:0]);
            if (wel_clr)      wel <= 1'b0;
            else if (wel_set) wel <= 1'b1;
        end
    end

    // R2: the latch only rises after a complete enable frame
    a_r2_wel_from_wren: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wel) |-> $past(state == ST_WREN_END));

    // R5: a frame completes only through the data byte
    a_r5_lock_end_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOCK_END && $past(state) != ST_LOCK_END) |-> $past(state == ST_DATA));

endmodule

// File: rtl/slk_lock_bank.sv
module slk_lock_bank
    import slk_pkg::*;
#(
    parameter int N_SECT = 8,
    localparam int SECT_W = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [SECT_W-1:0] wsel,
    input  lock_t             wdata,
    input  logic [SECT_W-1:0] rsel,
    output logic [1:0]        rdata,
    output logic [N_SECT-1:0] wp_vec
);

    lock_t regs [N_SECT];

    generate
        for (genvar s = 0; s < N_SECT; s++) begin : g_sect
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    regs[s] <= '0;
                else if (we && wsel == SECT_W'(s) && !regs[s].down)
                    regs[s] <= wdata;
            end
            assign wp_vec[s] = regs[s].wlock;

            // R9: a locked-down sector never changes
            a_r9_lockdown_freeze: assert property (@(posedge clk) disable iff (!rst_n)
                $past(regs[s].down) |-> $stable(regs[s]));
        end
    endgenerate

    assign rdata = regs[rsel];

endmodule

// File: rtl/sector_lock_ctrl.sv
module sector_lock_ctrl
    import slk_pkg::*;
#(
    parameter int N_SECT      = 8,
    parameter int SECT_LSB    = 16,
    parameter int SYNC_STAGES = 2,
    localparam int SECT_W     = $clog2(N_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_mosi,
    input  logic              busy,
    input  logic [SECT_W-1:0] rd_sector,
    output logic [1:0]        rd_lock,
    output logic [N_SECT-1:0] wp_vec,
    output logic              wel
);

    logic              cs_fall, cs_rise, bit_stb, byte_stb;
    logic [7:0]        byte_val;
    logic              commit;
    logic [SECT_W-1:0] commit_sector;
    lock_t             commit_data;

    slk_spi_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n_in  (spi_cs_n),
        .sclk_in  (spi_sclk),
        .mosi_in  (spi_mosi),
        .cs_fall  (cs_fall),
        .cs_rise  (cs_rise),
        .bit_stb  (bit_stb),
        .byte_stb (byte_stb),
        .byte_val (byte_val)
    );

    slk_cmd_fsm #(.SECT_W(SECT_W), .SECT_LSB(SECT_LSB)) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cs_fall       (cs_fall),
        .cs_rise       (cs_rise),
        .bit_stb       (bit_stb),
        .byte_stb      (byte_stb),
        .byte_val      (byte_val),
        .busy          (busy),
        .wel           (wel),
        .commit        (commit),
        .commit_sector (commit_sector),
        .commit_data   (commit_data)
    );

    slk_lock_bank #(.N_SECT(N_SECT)) u_bank (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (commit),
        .wsel   (commit_sector),
        .wdata  (commit_data),
        .rsel   (rd_sector),
        .rdata  (rd_lock),
        .wp_vec (wp_vec)
    );

    // R6: protection changes only if the latch was set
    a_r6_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_vec != $past(wp_vec)) |-> $past(wel));

    // R7: no change commits while busy
    a_r7_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_vec != $past(wp_vec)) |-> !$past(busy));

    // R5: changes follow a select release
    a_r5_on_cs_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_vec != $past(wp_vec)) |-> $past(cs_rise));

    // R8: latch is clear once a change is visible
    a_r8_wel_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_vec != $past(wp_vec)) |-> !wel);

endmodule

// File: tb/test_sector_lock_ctrl.sv
module test_sector_lock_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int HALF_BIT   = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_mosi = 1'b0;
    logic       busy = 1'b0;
    logic [2:0] rd_sector = '0;
    logic [1:0] rd_lock;
    logic [7:0] wp_vec;
    logic       wel;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;

    sector_lock_ctrl i_sector_lock_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_cs_n  (spi_cs_n),
        .spi_sclk  (spi_sclk),
        .spi_mosi  (spi_mosi),
        .busy      (busy),
        .rd_sector (rd_sector),
        .rd_lock   (rd_lock),
        .wp_vec    (wp_vec),
        .wel       (wel)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got %0d cycles expected < 150000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    // send the top n bits of v, MSB first, inside one select window
    task automatic frame(input logic [47:0] v, input int n);
        spi_cs_n = 1'b0;
        idle(HALF_BIT);
        for (int i = 0; i < n; i++) begin
            spi_mosi = v[47 - i];
            idle(HALF_BIT);
            spi_sclk = 1'b1;
            idle(HALF_BIT);
            spi_sclk = 1'b0;
        end
        idle(HALF_BIT);
        spi_cs_n = 1'b1;
        idle(8);
        @(negedge clk);
    endtask

    task automatic wren();
        frame({8'h06, 40'h0}, 8);
    endtask

    task automatic lock_wr(input logic [23:0] addr, input logic [7:0] data, input int n);
        frame({8'hE5, addr, data, 8'h00}, n);
    endtask

    task automatic check_sect(input string req, input int s, input logic [1:0] exp);
        rd_sector = 3'(s);
        #1;
        check(req, 32'(rd_lock), 32'(exp));
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R1 wp_vec", 32'(wp_vec), 32'h0);
        check("R1 wel", 32'(wel), 32'h0);
        for (int s = 0; s < 8; s++) check_sect("R1 sector reg", s, 2'b00);
    endtask

    task automatic t_wren();
        wren();
        check("R2 wel set", 32'(wel), 32'h1);
    endtask

    task automatic t_basic();
        lock_wr(24'h03_1234, 8'h01, 40);
        check("R3 wp_vec", 32'(wp_vec), 32'h08);
        check_sect("R3 sector 3", 3, 2'b01);
        check_sect("R3 sector 2 untouched", 2, 2'b00);
        check("R8 wel cleared", 32'(wel), 32'h0);
    endtask

    task automatic t_addr_bits();
        wren();
        lock_wr(24'hF8_ABCD, 8'hFD, 40);
        check_sect("R4 high/low addr bits ignored", 0, 2'b01);
        wren();
        lock_wr(24'h05_FFFF, 8'h01, 40);
        check("R4 wp_vec sector 5", 32'(wp_vec), 32'h29);
        check_sect("R11 read sector 5", 5, 2'b01);
    endtask

    task automatic t_bad_count();
        wren();
        lock_wr(24'h06_0000, 8'h01, 39);
        check_sect("R5 39 bits no effect", 6, 2'b00);
        check("R5 wel kept (39)", 32'(wel), 32'h1);
        lock_wr(24'h06_0000, 8'h01, 41);
        check_sect("R5 41 bits no effect", 6, 2'b00);
        check("R5 wel kept (41)", 32'(wel), 32'h1);
    endtask

    task automatic t_no_wel();
        lock_wr(24'h07_0000, 8'h00, 40);
        check("R8 wel cleared again", 32'(wel), 32'h0);
        lock_wr(24'h06_0000, 8'h01, 40);
        check_sect("R6 no latch no write", 6, 2'b00);
        check("R6 wp_vec", 32'(wp_vec), 32'h29);
    endtask

    task automatic t_busy();
        wren();
        busy = 1'b1;
        lock_wr(24'h06_0000, 8'h01, 40);
        check_sect("R7 busy rejects", 6, 2'b00);
        check("R7 wel kept", 32'(wel), 32'h1);
        busy = 1'b0;
        idle(2);
        @(negedge clk);
    endtask

    task automatic t_lockdown();
        lock_wr(24'h02_0000, 8'h03, 40);
        check_sect("R9 lock-down set", 2, 2'b11);
        wren();
        lock_wr(24'h02_8000, 8'h00, 40);
        check_sect("R9 frozen sector", 2, 2'b11);
        check("R9 wel cleared", 32'(wel), 32'h0);
        wren();
        lock_wr(24'h03_0000, 8'h00, 40);
        check_sect("R3 unlock sector 3", 3, 2'b00);
        check("R3 wp_vec after unlock", 32'(wp_vec), 32'h25);
    endtask

    task automatic t_bad_opcode();
        wren();
        frame({8'hA5, 24'h06_0000, 8'h01, 8'h00}, 40);
        check_sect("R10 unknown opcode", 6, 2'b00);
        check("R10 wel kept", 32'(wel), 32'h1);
        check("R10 wp_vec", 32'(wp_vec), 32'h25);
    endtask

    initial begin
        idle(5);
        rst_n = 1'b1;
        idle(3);
        t_reset();
        t_wren();
        t_basic();
        t_addr_bits();
        t_bad_count();
        t_no_wel();
        t_busy();
        t_lockdown();
        t_bad_opcode();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule